// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the multiply and accumulate engine of an integer core. It holds a 64-bit accumulator in two 32-bit halves, the high half and the low half. Each cycle it takes an operation code and two 32-bit operands, which are already fetched, and updates the halves in a single clock. The operations are:

- full-width signed and unsigned products;
- a product that keeps only its low word;
- signed and unsigned products of the low halfwords;
- clearing the accumulator;
- two accumulate forms, a long one on the full operands and a word one on the low halfwords.

A saturation input changes how the two accumulate forms finish. Long accumulation clamps to a 48-bit signed range. Word accumulation clamps to a 32-bit signed range in the low half and records the overflow by writing 1 into the high half. Either half can also be loaded directly through its own write port, so software can save and restore the accumulator or seed it.

The halves are visible on two output ports at all times. An operation presented in one cycle is reflected on those ports after the next rising clock edge.

Top module: `mac_unit`

## Requirements

Operation codes on `op_code`: 0 no operation, 1 signed wide product, 2 unsigned wide product, 3 low-word product, 4 signed halfword product, 5 unsigned halfword product, 6 clear, 7 long accumulate, 8 word accumulate. Codes 9 to 15 are unused.

- R1: Codes 1 and 2 form the 64-bit product of `src_a` and `src_b`. Code 1 treats both operands as two's complement and code 2 as unsigned. Product bits 63:32 go to the high half and bits 31:0 to the low half.
- R2: Code 3 writes bits 31:0 of the product of `src_a` and `src_b` to the low half and leaves the high half unchanged.
- R3: Codes 4 and 5 multiply bits 15:0 of both operands and write the 32-bit product to the low half, leaving the high half unchanged. Code 4 sign-extends the halfwords and code 5 zero-extends them.
- R4: Code 6 sets both halves to zero.
- R5: Code 7 with `sat_en` low adds the signed 64-bit product of the operands to {high, low}, modulo 2^64.
- R6: Code 7 with `sat_en` high computes the same sum exactly and then limits it to the range -2^47 .. 2^47-1. A sum above the range gives 0x0000_7FFF_FFFF_FFFF and a sum below it gives 0xFFFF_8000_0000_0000.
- R7: Code 8 with `sat_en` high adds the signed product of the low halfwords to the low half as a 32-bit signed value. On overflow the low half becomes 0x7FFF_FFFF (or 0x8000_0000 when the overflow is negative) and the high half becomes 1. Without overflow the high half is unchanged.
- R8: Code 8 with `sat_en` low sign-extends the signed halfword product to 64 bits and adds it to {high, low}, modulo 2^64.
- R9: When `hi_wr_en` or `lo_wr_en` is high, that half takes the matching write data after the clock edge. This overrides whatever the operation in the same cycle would have put there. The other half follows the operation.
- R10: Synchronous reset clears both halves and takes priority over the write ports. Code 0 and the unused codes leave both halves unchanged.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code, encoding as in the requirements |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| sat_en | input | 1 | Saturation mode for codes 7 and 8 |
| hi_wr_en | input | 1 | Load enable for the high half |
| hi_wr_data | input | 32 | Data loaded into the high half |
| lo_wr_en | input | 1 | Load enable for the low half |
| lo_wr_data | input | 32 | Data loaded into the low half |
| acc_hi | output | 32 | High half of the accumulator |
| acc_lo | output | 32 | Low half of the accumulator |

## Verification

The hardest case to reach from the ports is negative saturation of the long accumulate. Getting there by repeated accumulation would take many cycles of large negative products. The stimulus instead uses the write ports to place the accumulator exactly at the lower 48-bit limit. It then adds a small negative product once with saturation and once without: the first run must stay pinned at the limit and the second must wrap below it.

The overflow marker of the word accumulate is reached the same way. The low half is preloaded a few counts from either 32-bit limit and the high half is given an unrelated value, so that the change to 1 can be seen.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 2 * WORD_W;
    localparam int LSAT_W = 48;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 4'd0,
        OP_MULS_WIDE = 4'd1,
        OP_MULU_WIDE = 4'd2,
        OP_MUL_LOW   = 4'd3,
        OP_MULS_HALF = 4'd4,
        OP_MULU_HALF = 4'd5,
        OP_CLEAR     = 4'd6,
        OP_MAC_LONG  = 4'd7,
        OP_MAC_WORD  = 4'd8
    } mac_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd8;

    // Operand extension controls for the shared multipliers
    typedef struct packed {
        logic wide_signed;
        logic half_signed;
    } mul_ctl_t;

    // Next-state proposal for the accumulator halves
    typedef struct packed {
        logic              hi_upd;
        logic              lo_upd;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } acc_next_t;

    function automatic mul_ctl_t decode_mul(mac_op_e op);
        mul_ctl_t c;
        c.wide_signed = (op == OP_MULS_WIDE) || (op == OP_MAC_LONG);
        c.half_signed = (op == OP_MULS_HALF) || (op == OP_MAC_WORD);
        return c;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int WORD_W = mac_pkg::WORD_W,
    parameter int HALF_W = mac_pkg::HALF_W
) (
    input  mul_ctl_t            ctl,
    input  logic [WORD_W-1:0]   src_a,
    input  logic [WORD_W-1:0]   src_b,
    output logic [2*WORD_W-1:0] prod_wide,
    output logic [WORD_W-1:0]   prod_half
);
    localparam int PW = 2 * WORD_W;

    // One extra top bit selects sign or zero extension, so one signed
    // multiplier serves both the signed and the unsigned variant.
    logic signed [WORD_W:0] ext_a, ext_b;
    logic signed [PW-1:0]   wide_a, wide_b;
    logic signed [HALF_W:0] hext_a, hext_b;
    logic signed [WORD_W-1:0] half_a, half_b;

    always_comb begin
        ext_a  = {ctl.wide_signed & src_a[WORD_W-1], src_a};
        ext_b  = {ctl.wide_signed & src_b[WORD_W-1], src_b};
        wide_a = PW'(ext_a);
        wide_b = PW'(ext_b);
        prod_wide = wide_a * wide_b;
    end

    always_comb begin
        hext_a = {ctl.half_signed & src_a[HALF_W-1], src_a[HALF_W-1:0]};
        hext_b = {ctl.half_signed & src_b[HALF_W-1], src_b[HALF_W-1:0]};
        half_a = WORD_W'(hext_a);
        half_b = WORD_W'(hext_b);
        prod_half = half_a * half_b;
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int WORD_W = mac_pkg::WORD_W,
    parameter int LSAT_W = mac_pkg::LSAT_W
) (
    input  mac_op_e             op,
    input  logic                sat_en,
    input  logic [WORD_W-1:0]   acc_hi,
    input  logic [WORD_W-1:0]   acc_lo,
    input  logic [2*WORD_W-1:0] prod_wide,
    input  logic [WORD_W-1:0]   prod_half,
    output acc_next_t           nxt
);
    localparam int AW    = 2 * WORD_W;
    localparam int SUM_W = AW + 1;
    localparam int TOP_W = SUM_W - (LSAT_W - 1);

    localparam logic [AW-1:0]     LMAX = {{(AW - LSAT_W + 1){1'b0}}, {(LSAT_W - 1){1'b1}}};
    localparam logic [AW-1:0]     LMIN = ~LMAX;
    localparam logic [WORD_W-1:0] WMAX = {1'b0, {(WORD_W - 1){1'b1}}};
    localparam logic [WORD_W-1:0] WMIN = ~WMAX;

    logic [AW-1:0]     acc;
    logic [SUM_W-1:0]  sum_long;
    logic [TOP_W-1:0]  long_top;
    logic              long_ovf;
    logic [AW-1:0]     long_res;
    logic [WORD_W:0]   sum_word;
    logic              word_ovf;
    logic [AW-1:0]     word_wide;

    // Long accumulate: exact sum with one guard bit, then 48-bit clamp
    always_comb begin
        acc      = {acc_hi, acc_lo};
        sum_long = {acc[AW-1], acc} + {prod_wide[AW-1], prod_wide};
        long_top = sum_long[SUM_W-1:LSAT_W-1];
        long_ovf = !((&long_top) || !(|long_top));
        if (sat_en && long_ovf)
            long_res = sum_long[SUM_W-1] ? LMIN : LMAX;
        else
            long_res = sum_long[AW-1:0];
    end

    // Word accumulate: 33-bit sum for the saturating form, 64-bit otherwise
    always_comb begin
        sum_word  = {acc_lo[WORD_W-1], acc_lo} + {prod_half[WORD_W-1], prod_half};
        word_ovf  = sum_word[WORD_W] ^ sum_word[WORD_W-1];
        word_wide = acc + {{WORD_W{prod_half[WORD_W-1]}}, prod_half};
    end

    always_comb begin
        nxt = '0;
        unique case (op)
            OP_MULS_WIDE, OP_MULU_WIDE: begin
                nxt.hi_upd = 1'b1;
                nxt.lo_upd = 1'b1;
                nxt.hi     = prod_wide[AW-1:WORD_W];
                nxt.lo     = prod_wide[WORD_W-1:0];
            end
            OP_MUL_LOW: begin
                nxt.lo_upd = 1'b1;
                nxt.lo     = prod_wide[WORD_W-1:0];
            end
            OP_MULS_HALF, OP_MULU_HALF: begin
                nxt.lo_upd = 1'b1;
                nxt.lo     = prod_half;
            end
            OP_CLEAR: begin
                nxt.hi_upd = 1'b1;
                nxt.lo_upd = 1'b1;
            end
            OP_MAC_LONG: begin
                nxt.hi_upd = 1'b1;
                nxt.lo_upd = 1'b1;
                nxt.hi     = long_res[AW-1:WORD_W];
                nxt.lo     = long_res[WORD_W-1:0];
            end
            OP_MAC_WORD: begin
                nxt.lo_upd = 1'b1;
                if (sat_en) begin
                    nxt.hi_upd = word_ovf;
                    nxt.hi     = WORD_W'(1);
                    nxt.lo     = word_ovf ? (sum_word[WORD_W] ? WMIN : WMAX)
                                          : sum_word[WORD_W-1:0];
                end else begin
                    nxt.hi_upd = 1'b1;
                    nxt.hi     = word_wide[AW-1:WORD_W];
                    nxt.lo     = word_wide[WORD_W-1:0];
                end
            end
            default: nxt = '0;
        endcase
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int WORD_W = mac_pkg::WORD_W,
    parameter int HALF_W = mac_pkg::HALF_W,
    parameter int LSAT_W = mac_pkg::LSAT_W,
    parameter int OP_W   = mac_pkg::OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_code,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic              sat_en,
    input  logic              hi_wr_en,
    input  logic [WORD_W-1:0] hi_wr_data,
    input  logic              lo_wr_en,
    input  logic [WORD_W-1:0] lo_wr_data,
    output logic [WORD_W-1:0] acc_hi,
    output logic [WORD_W-1:0] acc_lo
);
    localparam int SAT_LSB = LSAT_W - 1 - WORD_W;
    localparam int SAT_TOP = WORD_W - SAT_LSB;

    mac_op_e             op;
    mul_ctl_t            mctl;
    logic [2*WORD_W-1:0] prod_wide;
    logic [WORD_W-1:0]   prod_half;
    acc_next_t           nxt;
    logic                op_unused;
    logic                no_write;
    logic [SAT_TOP-1:0]  hi_sat_bits;

    assign op        = mac_op_e'(op_code);
    assign mctl      = decode_mul(op);
    assign op_unused = (op_code > OP_LAST);
    assign no_write  = !hi_wr_en && !lo_wr_en;

    mac_mult #(.WORD_W(WORD_W), .HALF_W(HALF_W)) i_mult (
        .ctl       (mctl),
        .src_a     (src_a),
        .src_b     (src_b),
        .prod_wide (prod_wide),
        .prod_half (prod_half)
    );

    mac_accum #(.WORD_W(WORD_W), .LSAT_W(LSAT_W)) i_accum (
        .op        (op),
        .sat_en    (sat_en),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo),
        .prod_wide (prod_wide),
        .prod_half (prod_half),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else begin
            if (hi_wr_en)        acc_hi <= hi_wr_data;
            else if (nxt.hi_upd) acc_hi <= nxt.hi;
            if (lo_wr_en)        acc_lo <= lo_wr_data;
            else if (nxt.lo_upd) acc_lo <= nxt.lo;
        end
    end

    assign hi_sat_bits = acc_hi[WORD_W-1:SAT_LSB];

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd6 && no_write) |=> (acc_hi == '0 && acc_lo == '0)); // R4

    AST_HALF_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        ((op_code == 4'd3 || op_code == 4'd4 || op_code == 4'd5) && !hi_wr_en)
        |=> $stable(acc_hi)); // R3

    AST_LONG_SAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd7 && sat_en && no_write)
        |=> ((&hi_sat_bits) || !(|hi_sat_bits))); // R6

    AST_WORD_SAT_MARK: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd8 && sat_en && !hi_wr_en)
        |=> (acc_hi == WORD_W'(1) || $stable(acc_hi))); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        hi_wr_en |=> (acc_hi == $past(hi_wr_data))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((op_code == 4'd0 || op_unused) && no_write)
        |=> ($stable(acc_hi) && $stable(acc_lo))); // R10

endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        sat;
        logic        hwe;
        logic [31:0] hd;
        logic        lwe;
        logic [31:0] ld;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd2, 32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd1, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd3, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd4, 32'h0005_FFFF, 32'h7777_0002, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd5, 32'h0005_FFFF, 32'h7777_0002, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd4, 32'h0000_8000, 32'h0000_8000, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd6, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFF_8000, 1'b1, 32'h0000_0000},
        '{4'd7, 32'hFFFF_FFFF, 32'h0000_03E8, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd7, 32'hFFFF_FFFF, 32'h0000_03E8, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h7FFF_FFF0},
        '{4'd8, 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0000_0005, 1'b1, 32'h8000_0010},
        '{4'd8, 32'h0000_FFFF, 32'h0000_0100, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd8, 32'h0000_0003, 32'h0000_0004, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd8, 32'h0000_FFFF, 32'h0000_0002, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd8, 32'h0000_7FFF, 32'h0000_7FFF, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd7, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 32'h0, 1'b1, 32'hCAFE_F00D},
        '{4'd1, 32'h0000_0005, 32'h0000_0006, 1'b0, 1'b1, 32'h1111_2222, 1'b0, 32'h0},
        '{4'd15, 32'h0000_0009, 32'h0000_0009, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd0, 32'h1234_0000, 32'h0000_4321, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{4'd6, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0000_ABCD, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_code;
    logic [31:0] src_a, src_b, hi_wr_data, lo_wr_data;
    logic        sat_en, hi_wr_en, lo_wr_en;
    logic [31:0] acc_hi, acc_lo;

    logic [31:0] m_hi, m_lo;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    mac_unit i_mac_unit (
        .clk        (clk),
        .rst        (rst),
        .op_code    (op_code),
        .src_a      (src_a),
        .src_b      (src_b),
        .sat_en     (sat_en),
        .hi_wr_en   (hi_wr_en),
        .hi_wr_data (hi_wr_data),
        .lo_wr_en   (lo_wr_en),
        .lo_wr_data (lo_wr_data),
        .acc_hi     (acc_hi),
        .acc_lo     (acc_lo)
    );

    function automatic string tag_of(vec_t v);
        if (v.hwe || v.lwe) return "R9";
        case (v.op)
            4'd1, 4'd2: return "R1";
            4'd3:       return "R2";
            4'd4, 4'd5: return "R3";
            4'd6:       return "R4";
            4'd7:       return v.sat ? "R6" : "R5";
            4'd8:       return v.sat ? "R7" : "R8";
            default:    return "R10";
        endcase
    endfunction

    // Wide-integer reference of one operation applied to m_hi/m_lo
    task automatic model_step(vec_t v);
        logic [63:0]        acc, p;
        longint             sa, sb, hs, hu, w;
        logic signed [65:0] s;
        acc = {m_hi, m_lo};
        sa  = longint'(signed'(v.a));
        sb  = longint'(signed'(v.b));
        hs  = longint'(signed'(v.a[15:0])) * longint'(signed'(v.b[15:0]));
        hu  = longint'({48'h0, v.a[15:0]}) * longint'({48'h0, v.b[15:0]});
        case (v.op)
            4'd1: begin p = sa * sb; m_hi = p[63:32]; m_lo = p[31:0]; end
            4'd2: begin p = {32'h0, v.a} * {32'h0, v.b}; m_hi = p[63:32]; m_lo = p[31:0]; end
            4'd3: begin p = {32'h0, v.a} * {32'h0, v.b}; m_lo = p[31:0]; end
            4'd4: m_lo = hs[31:0];
            4'd5: m_lo = hu[31:0];
            4'd6: begin m_hi = 32'h0; m_lo = 32'h0; end
            4'd7: begin
                p = sa * sb;
                s = {{2{acc[63]}}, acc} + {{2{p[63]}}, p};
                if (v.sat) begin
                    if (s > 66'sh7FFF_FFFF_FFFF) s = 66'sh7FFF_FFFF_FFFF;
                    else if (s < -66'sh8000_0000_0000) s = -66'sh8000_0000_0000;
                end
                m_hi = s[63:32];
                m_lo = s[31:0];
            end
            4'd8: begin
                if (v.sat) begin
                    w = longint'(signed'(m_lo)) + hs;
                    if (w > 64'sd2147483647) begin
                        m_lo = 32'h7FFF_FFFF; m_hi = 32'h1;
                    end else if (w < -64'sd2147483648) begin
                        m_lo = 32'h8000_0000; m_hi = 32'h1;
                    end else begin
                        m_lo = w[31:0];
                    end
                end else begin
                    p = acc + hs;
                    m_hi = p[63:32];
                    m_lo = p[31:0];
                end
            end
            default: ;
        endcase
        if (v.hwe) m_hi = v.hd;
        if (v.lwe) m_lo = v.ld;
    endtask

    task automatic check(string tag, logic [31:0] hi_exp, logic [31:0] lo_exp);
        checks++;
        if (acc_hi !== hi_exp || acc_lo !== lo_exp) begin
            failures++;
            $display("FAIL %s: actual hi=%h lo=%h expected hi=%h lo=%h",
                     tag, acc_hi, acc_lo, hi_exp, lo_exp);
        end
    endtask

    task automatic drive(vec_t v);
        op_code    = v.op;
        src_a      = v.a;
        src_b      = v.b;
        sat_en     = v.sat;
        hi_wr_en   = v.hwe;
        hi_wr_data = v.hd;
        lo_wr_en   = v.lwe;
        lo_wr_data = v.ld;
    endtask

    initial begin
        rst = 1'b1;
        drive('0);
        m_hi = 32'h0;
        m_lo = 32'h0;
        repeat (3) @(negedge clk);
        check("R10 reset state", 32'h0, 32'h0);
        rst = 1'b0;

        // Table walk: drive at a falling edge, check at the next one
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            model_step(VECS[i]);
            @(negedge clk);
            check(tag_of(VECS[i]), m_hi, m_lo);
        end

        // R10: reset mid-run with both write ports active still clears
        drive('{4'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b1, 32'h0BAD_F00D});
        @(negedge clk);
        check("R9 preload before reset", 32'hDEAD_BEEF, 32'h0BAD_F00D);
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset beats writes", 32'h0, 32'h0);
        rst = 1'b0;
        drive('0);
        @(negedge clk);
        check("R10 idle after reset", 32'h0, 32'h0);

        // R6: sum exactly at the upper 48-bit limit is not clamped
        drive('{4'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0000_7FFF, 1'b1, 32'hFFFF_FFFE});
        @(negedge clk);
        drive('{4'd7, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0});
        @(negedge clk);
        check("R6 sum at limit", 32'h0000_7FFF, 32'hFFFF_FFFF);
        drive('{4'd7, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0});
        @(negedge clk);
        check("R6 one past limit", 32'h0000_7FFF, 32'hFFFF_FFFF);
        drive('{4'd7, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0});
        @(negedge clk);
        check("R5 no clamp without sat", 32'h0000_8000, 32'h0000_0000);

        // R7: word accumulate landing exactly on 0x7FFFFFFF keeps high half
        drive('{4'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0000_0042, 1'b1, 32'h7FFF_FFFB});
        @(negedge clk);
        drive('{4'd8, 32'h0000_0002, 32'h0003_0002, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0});
        @(negedge clk);
        check("R7 exact max no mark", 32'h0000_0042, 32'h7FFF_FFFF);

        drive('0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule